// File: doc/BRIEF.md
# Biphase Mark Line Transmitter

This block sends one frame at a time onto a single shared wire using biphase mark coding. The nominal rate is 300 kbit/s. The bit period is set by a fixed integer count of clock cycles per half unit interval (UI). A strobe on `startReq` opens a frame. The block then turns on its line driver and emits an alternating preamble that it generates itself. After the preamble it pulls payload bits from a valid/ready bit stream, and the upstream source marks the final bit with a last flag. Sync symbols and any line code are supplied by that source as ordinary payload bits.

After the final bit the block forces the wire low and holds it there for a set number of cycles, then releases the driver. From then on the wire floats at the level set by the external termination. The block then waits out a minimum idle gap, counted from the end of the last bit, before it will start another frame.

A start strobe that arrives while a frame or its gap is still running is not lost. It is kept and acted on as soon as the gap ends. The defaults assume a 12 MHz clock: 20 cycles per half UI, a 64-bit preamble, about 1.2 µs of low hold and about 25.8 µs of gap.

Top module: `bmc_tx_top`

## Requirements
- R1: While reset is asserted and afterwards with no start strobe, `lineOut`, `driveEn`, `busy`, `done` and `bitReady` are all 0.
- R2: A start strobe seen while idle is accepted on the next clock edge. From the cycle after that edge, `busy` and `driveEn` are 1 and `lineOut` has risen to 1, which is the leading edge of the first preamble bit.
- R3: Every frame begins with PREAMBLE_BITS preamble bits that alternate in value, the first one being 0.
- R4: Every bit lasts 2·HALF_UI_CYCLES cycles. The line level toggles at the start of each bit. A 1 bit toggles again HALF_UI_CYCLES cycles later; a 0 bit does not.
- R5: `bitReady` is a one-cycle pulse in the last cycle of the final preamble bit and in the last cycle of each payload bit, up to the bit flagged by `bitLast`. A bit is taken when `bitReady` and `bitValid` are both 1. After the flagged bit, no further `bitReady` pulse occurs.
- R6: If `bitValid` is 0 during a `bitReady` pulse, the frame ends at that bit boundary. The bits already sent stand as the whole frame.
- R7: At the end of the last bit the line is driven to 0, with an extra falling edge if it was high. It stays driven low for HOLD_LOW_CYCLES cycles, and then `driveEn` falls. The total driven time is 2·HALF_UI_CYCLES·(PREAMBLE_BITS+n)+HOLD_LOW_CYCLES cycles for n payload bits.
- R8: `done` is 1 for exactly one cycle: the first cycle in which `driveEn` is 0 after a frame.
- R9: `busy` stays 1 until GAP_CYCLES cycles after the end of the last bit. A start strobe received while `busy` is 1 is held. It is accepted one cycle after `busy` falls, so `busy` is low for exactly one cycle between the two frames.
- R10: A start strobe present exactly on the clock edge at which the gap expires is accepted on the following edge. It is neither lost nor taken early.
- R11: `lineOut` is 0 whenever `driveEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Request to send a frame |
| bitValid | input | 1 | Payload bit present on `bitData` |
| bitData | input | 1 | Payload bit value |
| bitLast | input | 1 | Marks the final payload bit |
| bitReady | output | 1 | Transmitter takes the presented bit at this edge |
| lineOut | output | 1 | Encoded line level |
| driveEn | output | 1 | Line driver enable |
| busy | output | 1 | Frame or idle gap in progress |
| done | output | 1 | One-cycle pulse on driver release |

## Verification
Two things can land on the same clock edge: a new start strobe and the expiry of the inter-frame gap. The bench measures the cycle at which the driver released. From that it computes the edge on which the gap counter runs out, and it raises `startReq` for exactly that edge. The bench then expects `busy` and `driveEn` to be low in the following cycle, and the new preamble to begin exactly GAP−HOLD+1 cycles after the release. A second pairing is also provoked: a bit-boundary `bitReady` pulse falls in the same cycle as an empty stream. The bench judges this by the driven length and by the count of ready pulses.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_TAIL,
    ST_GAP
  } txState_e;

  // strobes from control to the line datapath, one cycle each
  typedef struct packed {
    logic frameGo;     // open the driver, first boundary edge
    logic edgeToggle;  // bit-boundary transition
    logic midEdge;     // mid-bit transition for a 1
    logic tailLow;     // force the line low after the last bit
    logic lineFree;    // release the driver
  } txStrobe_t;

endpackage

// File: rtl/bmc_tx_line.sv
module bmc_tx_line
  import bmc_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  txStrobe_t strobe,
  output logic      lineOut,
  output logic      driveEn,
  output logic      done
);

  logic lineQ;
  logic driveQ;
  logic doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ  <= 1'b0;
      driveQ <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      if (strobe.tailLow) lineQ <= 1'b0;
      else if (strobe.edgeToggle || strobe.midEdge) lineQ <= ~lineQ;

      if (strobe.frameGo) driveQ <= 1'b1;
      else if (strobe.lineFree) driveQ <= 1'b0;

      doneQ <= strobe.lineFree;
    end
  end

  assign lineOut = lineQ;
  assign driveEn = driveQ;
  assign done    = doneQ;

endmodule

// File: rtl/bmc_tx_ctrl.sv
module bmc_tx_ctrl
  import bmc_tx_pkg::*;
#(
  parameter int HALF_UI_CYCLES  = 20,
  parameter int PREAMBLE_BITS   = 64,
  parameter int HOLD_LOW_CYCLES = 14,
  parameter int GAP_CYCLES      = 310
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      bitValid,
  input  logic      bitData,
  input  logic      bitLast,
  output logic      bitReady,
  output logic      busy,
  output txStrobe_t strobe
);

  localparam int HW = (HALF_UI_CYCLES > 1) ? $clog2(HALF_UI_CYCLES) : 1;
  localparam int PW = (PREAMBLE_BITS > 1) ? $clog2(PREAMBLE_BITS) : 1;
  localparam int TW = $clog2(GAP_CYCLES + 1);
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_UI_CYCLES - 1);
  localparam logic [PW-1:0] PRE_LAST  = PW'(PREAMBLE_BITS - 1);
  localparam logic [TW-1:0] HOLD_LAST = TW'(HOLD_LOW_CYCLES - 1);
  localparam logic [TW-1:0] GAP_LAST  = TW'(GAP_CYCLES - 1);

  txState_e       state;
  logic [HW-1:0]  halfCnt;
  logic           phase;     // 0: first half of bit, 1: second half
  logic [PW-1:0]  bitIdx;
  logic           curBit;
  logic           lastFlag;
  logic [TW-1:0]  tailCnt;
  logic           pending;

  logic sending, atHalfEnd, atBitEnd, preDone, nextPre, take, finish, accept;

  always_comb begin
    sending   = (state == ST_PRE) || (state == ST_DATA);
    atHalfEnd = sending && (halfCnt == HALF_LAST);
    atBitEnd  = atHalfEnd && phase;
    preDone   = (state == ST_PRE) && (bitIdx == PRE_LAST);
    bitReady  = atBitEnd && (preDone || ((state == ST_DATA) && !lastFlag));
    take      = bitReady && bitValid;
    nextPre   = atBitEnd && (state == ST_PRE) && !preDone;
    finish    = atBitEnd && !take && !nextPre;
    accept    = (state == ST_IDLE) && (startReq || pending);

    strobe.frameGo    = accept;
    strobe.edgeToggle = accept || nextPre || take;
    strobe.midEdge    = atHalfEnd && !phase && curBit;
    strobe.tailLow    = finish;
    strobe.lineFree   = (state == ST_TAIL) && (tailCnt == HOLD_LAST);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      halfCnt  <= '0;
      phase    <= 1'b0;
      bitIdx   <= '0;
      curBit   <= 1'b0;
      lastFlag <= 1'b0;
      tailCnt  <= '0;
      pending  <= 1'b0;
    end else begin
      if (accept) pending <= 1'b0;
      else if (startReq) pending <= 1'b1;

      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_PRE;
            halfCnt  <= '0;
            phase    <= 1'b0;
            bitIdx   <= '0;
            curBit   <= 1'b0;
            lastFlag <= 1'b0;
          end
        end
        ST_PRE, ST_DATA: begin
          if (atHalfEnd) begin
            halfCnt <= '0;
            phase   <= ~phase;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
          if (nextPre) begin
            bitIdx <= bitIdx + 1'b1;
            curBit <= ~curBit;
          end
          if (take) begin
            state    <= ST_DATA;
            curBit   <= bitData;
            lastFlag <= bitLast;
          end
          if (finish) begin
            state   <= ST_TAIL;
            tailCnt <= '0;
          end
        end
        ST_TAIL: begin
          tailCnt <= tailCnt + 1'b1;
          if (tailCnt == HOLD_LAST) state <= ST_GAP;
        end
        ST_GAP: begin
          tailCnt <= tailCnt + 1'b1;
          if (tailCnt == GAP_LAST) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bmc_tx_top.sv
module bmc_tx_top
  import bmc_tx_pkg::*;
#(
  parameter int HALF_UI_CYCLES  = 20,
  parameter int PREAMBLE_BITS   = 64,
  parameter int HOLD_LOW_CYCLES = 14,
  parameter int GAP_CYCLES      = 310
) (
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic bitValid,
  input  logic bitData,
  input  logic bitLast,
  output logic bitReady,
  output logic lineOut,
  output logic driveEn,
  output logic busy,
  output logic done
);

  txStrobe_t strobe;

  bmc_tx_ctrl #(
    .HALF_UI_CYCLES (HALF_UI_CYCLES),
    .PREAMBLE_BITS  (PREAMBLE_BITS),
    .HOLD_LOW_CYCLES(HOLD_LOW_CYCLES),
    .GAP_CYCLES     (GAP_CYCLES)
  ) ctrlI (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .bitValid(bitValid),
    .bitData (bitData),
    .bitLast (bitLast),
    .bitReady(bitReady),
    .busy    (busy),
    .strobe  (strobe)
  );

  bmc_tx_line lineI (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .lineOut(lineOut),
    .driveEn(driveEn),
    .done   (done)
  );

endmodule

// File: rtl/bmc_tx_checker.sv
module bmc_tx_checker (
  input logic clk,
  input logic rstN,
  input logic bitReady,
  input logic lineOut,
  input logic driveEn,
  input logic busy,
  input logic done
);

  AST_DONE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(driveEn) |-> done);  // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R8
  AST_LOW_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(driveEn) |-> $past(!lineOut));  // R7
  AST_QUIET_UNDRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    !driveEn |-> !lineOut);  // R11
  AST_DRIVE_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    driveEn |-> busy);  // R9
  AST_READY_WHILE_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    bitReady |-> driveEn);  // R5
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    bitReady |=> !bitReady);  // R5
  AST_FRAME_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (driveEn && lineOut));  // R2

endmodule

bind bmc_tx_top bmc_tx_checker chkI (
  .clk     (clk),
  .rstN    (rstN),
  .bitReady(bitReady),
  .lineOut (lineOut),
  .driveEn (driveEn),
  .busy    (busy),
  .done    (done)
);

// File: tb/bmc_tx_top_tb_top.sv
module bmc_tx_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int PRE  = 8;
  localparam int HOLD = 3;
  localparam int GAP  = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic bitValid = 1'b0;
  logic bitData = 1'b0;
  logic bitLast = 1'b0;
  logic bitReady, lineOut, driveEn, busy, done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int readyCnt = 0;
  int doneCnt = 0;
  int expHalf[$];
  int expHalves[$];
  int expLen[$];
  bit cap[$];
  bit drvPrev = 1'b0;

  bmc_tx_top #(
    .HALF_UI_CYCLES (HALF),
    .PREAMBLE_BITS  (PRE),
    .HOLD_LOW_CYCLES(HOLD),
    .GAP_CYCLES     (GAP)
  ) dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .bitValid(bitValid),
    .bitData (bitData),
    .bitLast (bitLast),
    .bitReady(bitReady),
    .lineOut (lineOut),
    .driveEn (driveEn),
    .busy    (busy),
    .done    (done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver side of the scoreboard: expected half-UI levels for one frame
  task automatic pushExpected(input logic [31:0] pat, input int n);
    int lvl = 0;
    for (int i = 0; i < PRE + n; i++) begin
      int b = (i < PRE) ? (i % 2) : int'(pat[i - PRE]);
      lvl ^= 1;
      expHalf.push_back(lvl);
      if (b != 0) lvl ^= 1;
      expHalf.push_back(lvl);
    end
    expHalves.push_back(2 * (PRE + n));
    expLen.push_back(2 * HALF * (PRE + n) + HOLD);
  endtask

  task automatic compareFrame();
    int n, len, e, act;
    bit ok;
    if (expLen.size() == 0) begin
      check(1'b0, "R2 unexpected frame", cap.size(), 0);
      return;
    end
    n = expHalves.pop_front();
    len = expLen.pop_front();
    check(cap.size() == len, "R7 driven length", cap.size(), len);
    for (int k = 0; k < n; k++) begin
      e = expHalf.pop_front();
      ok = 1'b1;
      act = (k * HALF < cap.size()) ? int'(cap[k * HALF]) : -1;
      for (int j = 0; j < HALF; j++) begin
        int idx = k * HALF + j;
        if (idx >= cap.size() || int'(cap[idx]) != e) ok = 1'b0;
      end
      check(ok, (k < 2 * PRE) ? "R3 preamble half-UI level" : "R4 payload half-UI level", act, e);
    end
    ok = (cap.size() > n * HALF);
    for (int idx = n * HALF; idx < cap.size(); idx++) if (cap[idx]) ok = 1'b0;
    check(ok, "R7 tail held low", int'(ok), 1);
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (bitReady) readyCnt++;
      if (done) doneCnt++;
      if (driveEn && !drvPrev) cap.delete();
      if (driveEn) cap.push_back(lineOut);
      if (!driveEn && drvPrev) begin
        check(done == 1'b1, "R8 done with release", int'(done), 1);
        compareFrame();
      end
      drvPrev = driveEn;
    end
  end

  task automatic strobeStart(input bit checkOpen);
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    if (checkOpen) begin
      check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
      check(driveEn == 1'b1, "R2 drive after start", int'(driveEn), 1);
      check(lineOut == 1'b1, "R2 first edge", int'(lineOut), 1);
    end
  endtask

  task automatic feed(input logic [31:0] pat, input int n, input bit useLast);
    int idx = 0;
    bitValid = 1'b1;
    bitData = pat[0];
    bitLast = useLast && (n == 1);
    while (idx < n) begin
      @(negedge clk);
      if (bitReady) begin
        idx++;
        @(posedge clk);
        #1;
        if (idx < n) begin
          bitData = pat[idx];
          bitLast = useLast && (idx == n - 1);
        end else begin
          bitValid = 1'b0;
          bitLast = 1'b0;
        end
      end
    end
  endtask

  task automatic waitFall(output int f);
    @(negedge clk);
    while (!driveEn) @(negedge clk);
    while (driveEn) @(negedge clk);
    f = cyc;
  endtask

  task automatic waitBusyLow(output int b);
    while (busy) @(negedge clk);
    b = cyc;
  endtask

  task automatic singleFrame(input logic [31:0] pat, input int n, input bit useLast, input int readyExp);
    int f, b;
    readyCnt = 0;
    doneCnt = 0;
    pushExpected(pat, n);
    strobeStart(1'b1);
    feed(pat, n, useLast);
    waitFall(f);
    waitBusyLow(b);
    check(b - f == GAP - HOLD, "R9 busy through gap", b - f, GAP - HOLD);
    check(readyCnt == readyExp, useLast ? "R5 ready pulses" : "R6 underrun ready pulses", readyCnt, readyExp);
    check(doneCnt == 1, "R8 single done pulse", doneCnt, 1);
  endtask

  initial begin
    int f, r, b, lowCnt;
    repeat (3) @(negedge clk);
    check(lineOut == 1'b0, "R1 line in reset", int'(lineOut), 0);
    check(driveEn == 1'b0, "R1 drive in reset", int'(driveEn), 0);
    check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    check(bitReady == 1'b0, "R1 ready in reset", int'(bitReady), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !driveEn && !lineOut, "R1 idle after reset", int'(busy), 0);

    singleFrame(32'hB2, 8, 1'b1, 8);   // even zero count: ends low
    singleFrame(32'h1F, 5, 1'b1, 5);   // all ones
    singleFrame(32'h0, 3, 1'b1, 3);    // odd zero count: extra falling edge
    singleFrame(32'h5, 3, 1'b0, 4);    // R6 stream runs dry

    // held request during a frame (R9)
    readyCnt = 0;
    doneCnt = 0;
    pushExpected(32'h5A, 8);
    pushExpected(32'h3, 2);
    strobeStart(1'b1);
    repeat (5) @(negedge clk);
    strobeStart(1'b0);
    feed(32'h5A, 8, 1'b1);
    waitFall(f);
    lowCnt = 0;
    fork
      feed(32'h3, 2, 1'b1);
      begin
        while (!driveEn) begin
          if (!busy) lowCnt++;
          @(negedge clk);
        end
        r = cyc;
      end
    join
    check(r - f == GAP - HOLD + 1, "R9 held start timing", r - f, GAP - HOLD + 1);
    check(lowCnt == 1, "R9 busy low one cycle", lowCnt, 1);
    waitFall(f);
    waitBusyLow(b);
    check(readyCnt == 10, "R5 ready pulses two frames", readyCnt, 10);
    check(doneCnt == 2, "R8 done per frame", doneCnt, 2);

    // strobe exactly on the gap-expiry edge (R10)
    pushExpected(32'h9, 4);
    pushExpected(32'h1, 1);
    strobeStart(1'b1);
    feed(32'h9, 4, 1'b1);
    waitFall(f);
    while (cyc != f + GAP - HOLD - 1) @(negedge clk);
    check(busy == 1'b1, "R9 busy late in gap", int'(busy), 1);
    check(lineOut == 1'b0, "R11 line low while released", int'(lineOut), 0);
    startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    check(!busy && !driveEn, "R10 not accepted early", int'(driveEn), 0);
    fork
      feed(32'h1, 1, 1'b1);
      begin
        while (!driveEn) @(negedge clk);
        r = cyc;
      end
    join
    check(r - f == GAP - HOLD + 1, "R10 coincident start timing", r - f, GAP - HOLD + 1);
    waitFall(f);
    waitBusyLow(b);
    repeat (4) @(negedge clk);
    check(expLen.size() == 0, "R2 all expected frames seen", expLen.size(), 0);
    check(!busy && !driveEn, "R9 idle at end", int'(busy), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule